// File: doc/BRIEF.md
# Key-Protected Configuration Register File

This block is a word-addressed bank of 32-bit configuration and status registers that spans a 4 KB byte window. Software must first write a 16-bit unlock key to a dedicated offset before any ordinary register accepts data. A second key, written to another dedicated offset, closes the bank again. The bank comes out of reset closed.

Every word offset belongs to one access class: read-write, read-only, write-only or unmapped. An access that the class forbids is dropped and raises a one-cycle error flag. Writes that reach a writable register while the bank is closed are treated the same way. A few words load fixed values or a strap input at reset. One control word requests a system soft reset when its bit 0 is written while the bank is open.

The bus has no backpressure. A request is a single cycle with `busValid` high. The response, the error flag and the soft-reset pulse all appear in the following cycle.

Top module: `keyRegFile`

## Requirements
- R1: After reset, the lock-status word (byte 0x00C) reads 1, the PLL-status word (0x10C) reads 0x3F, the boot word (0x25C) reads the 4-bit `bootStrap` value zero-extended, the ID word (0x530) reads parameter `ID_CODE`, and every other word reads 0.
- R2: A write to 0x004 whose low 16 bits equal 0x767B sets lock status to 1. Any other value there changes nothing and is not flagged.
- R3: A write to 0x008 whose low 16 bits equal 0xDF0D clears lock status to 0. Any other value there changes nothing and is not flagged. Key writes are honoured whether the bank is locked or not.
- R4: While lock status is 1, a write to any read-write or write-only word other than the key words is discarded, and `accErr` pulses in the next cycle.
- R5: While unlocked, a write to a read-write word is stored. A read returns the word with `rspValid` high for exactly one cycle, in the cycle after the request. Read-write words are 0x000, 0x100–0x108, 0x120–0x16C, 0x200–0x244 and 0x700–0x7D4.
- R6: A write to a read-only word (0x00C, 0x10C, 0x25C, 0x530) or to an unmapped word is dropped and flagged, locked or not.
- R7: A read of a write-only word (0x004, 0x008, 0x60C, 0x614) or of an unmapped word returns the stored word and flags `accErr`. Write-only words accept writes when unlocked. Reads of read-write and read-only words are not flagged.
- R8: A write to word 0x000 stores only data bit 0. All other bits read back as 0.
- R9: An accepted write to 0x200 with data bit 0 set makes `softRstReq` high for exactly one cycle, in the next cycle. Nothing else raises it.
- R10: The two low address bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bootStrap | input | 4 | Strap value loaded into the boot word at reset |
| busValid | input | 1 | Request strobe, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W (12) | Byte offset |
| busWdata | input | DATA_W (32) | Write data |
| rspValid | output | 1 | Read data valid, one cycle after a read |
| rspData | output | DATA_W (32) | Read data |
| accErr | output | 1 | One-cycle pulse for an illegal access |
| softRstReq | output | 1 | One-cycle soft-reset request |

## Verification
The bench targets several mistakes a faulty design could make:

- Letting ordinary writes through before the unlock key, so a locked bank changes.
- Accepting a near-miss key, which opens or closes the bank on a wrong value.
- Failing to flag a read of a write-only word, or returning zero for it instead of the stored data.
- Storing upper bits of word 0x000.
- Raising the soft-reset request from a locked or bit-0-clear write.

The directed cases also alias the same word through all four low-address patterns. Random traffic mixes correct and wrong keys with every access class, so that lock-state tracking errors show up in later reads.

// File: rtl/keyRegFilePkg.sv
package keyRegFilePkg;
  typedef enum logic [1:0] {ACC_RW, ACC_RO, ACC_WO, ACC_NONE} accClass_t;

  typedef struct packed {
    logic wrEn;
    logic bit0Only;
    logic lockSet;
    logic lockClr;
    logic rdEn;
    logic err;
    logic softRst;
  } strobe_t;

  localparam logic [15:0] KEY_CLOSE = 16'h767B;
  localparam logic [15:0] KEY_OPEN  = 16'hDF0D;

  // word indices (byte offset / 4)
  localparam int W_LEVEL   = 'h000 >> 2;
  localparam int W_CLOSE   = 'h004 >> 2;
  localparam int W_OPEN    = 'h008 >> 2;
  localparam int W_LOCKSTA = 'h00C >> 2;
  localparam int W_PLLSTA  = 'h10C >> 2;
  localparam int W_RSTCTL  = 'h200 >> 2;
  localparam int W_BOOT    = 'h25C >> 2;
  localparam int W_IDENT   = 'h530 >> 2;

  function automatic accClass_t classify(input int w);
    if (w == W_CLOSE || w == W_OPEN || w == ('h60C >> 2) || w == ('h614 >> 2))
      return ACC_WO;
    if (w == W_LOCKSTA || w == W_PLLSTA || w == W_BOOT || w == W_IDENT)
      return ACC_RO;
    if (w == W_LEVEL ||
        (w >= ('h100 >> 2) && w <= ('h108 >> 2)) ||
        (w >= ('h120 >> 2) && w <= ('h16C >> 2)) ||
        (w >= ('h200 >> 2) && w <= ('h244 >> 2)) ||
        (w >= ('h700 >> 2) && w <= ('h7D4 >> 2)))
      return ACC_RW;
    return ACC_NONE;
  endfunction
endpackage

// File: rtl/keyRegCtrl.sv
module keyRegCtrl
  import keyRegFilePkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              lockState,
  output strobe_t           strobe
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] wordIdx;
  accClass_t         cls;
  logic              isClose, isOpen;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign cls     = classify(int'(wordIdx));
  assign isClose = int'(wordIdx) == W_CLOSE;
  assign isOpen  = int'(wordIdx) == W_OPEN;

  always_comb begin
    strobe = '0;
    if (busValid && busWrite) begin
      if (isClose) begin
        strobe.lockSet = busWdata[15:0] == KEY_CLOSE;
      end else if (isOpen) begin
        strobe.lockClr = busWdata[15:0] == KEY_OPEN;
      end else if (cls == ACC_RO || cls == ACC_NONE || lockState) begin
        strobe.err = 1'b1;
      end else begin
        strobe.wrEn     = 1'b1;
        strobe.bit0Only = int'(wordIdx) == W_LEVEL;
        strobe.softRst  = (int'(wordIdx) == W_RSTCTL) && busWdata[0];
      end
    end else if (busValid) begin
      strobe.rdEn = 1'b1;
      strobe.err  = cls == ACC_WO || cls == ACC_NONE;
    end
  end
endmodule

// File: rtl/keyRegData.sv
module keyRegData
  import keyRegFilePkg::*;
#(
  parameter int          ADDR_W  = 12,
  parameter int          DATA_W  = 32,
  parameter logic [31:0] ID_CODE = 32'h1C0D_E5A7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        bootStrap,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  strobe_t           strobe,
  output logic              lockState,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              accErr,
  output logic              softRstReq
);
  localparam int WORD_W = ADDR_W - 2;
  localparam int DEPTH  = 1 << WORD_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] wordIdx;

  assign wordIdx = busAddr[ADDR_W-1:2];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      mem[W_PLLSTA] <= DATA_W'(32'h3F);
      mem[W_BOOT]   <= DATA_W'(bootStrap);
      mem[W_IDENT]  <= DATA_W'(ID_CODE);
    end else if (strobe.wrEn) begin
      mem[wordIdx] <= strobe.bit0Only ? DATA_W'(busWdata[0]) : busWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockState  <= 1'b1;
      rspValid   <= 1'b0;
      rspData    <= '0;
      accErr     <= 1'b0;
      softRstReq <= 1'b0;
    end else begin
      if (strobe.lockSet)      lockState <= 1'b1;
      else if (strobe.lockClr) lockState <= 1'b0;
      rspValid   <= strobe.rdEn;
      accErr     <= strobe.err;
      softRstReq <= strobe.softRst;
      if (strobe.rdEn)
        rspData <= (int'(wordIdx) == W_LOCKSTA) ? DATA_W'(lockState) : mem[wordIdx];
    end
  end
endmodule

// File: rtl/keyRegFile.sv
module keyRegFile
  import keyRegFilePkg::*;
#(
  parameter int          ADDR_W  = 12,
  parameter int          DATA_W  = 32,
  parameter logic [31:0] ID_CODE = 32'h1C0D_E5A7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        bootStrap,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              accErr,
  output logic              softRstReq
);
  strobe_t strobe;
  logic    lockState;

  keyRegCtrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl_i (
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .lockState(lockState), .strobe(strobe)
  );

  keyRegData #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_CODE(ID_CODE)) data_i (
    .clk(clk), .rstN(rstN), .bootStrap(bootStrap), .busAddr(busAddr),
    .busWdata(busWdata), .strobe(strobe), .lockState(lockState),
    .rspValid(rspValid), .rspData(rspData), .accErr(accErr),
    .softRstReq(softRstReq)
  );
endmodule

// File: rtl/keyRegFileChecker.sv
module keyRegFileChecker #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              lockState,
  input logic              rspValid,
  input logic              accErr,
  input logic              softRstReq
);
  logic [ADDR_W-3:0] wordIdx;
  assign wordIdx = busAddr[ADDR_W-1:2];

  a_r2_close_key: assert property (@(posedge clk) disable iff (!rstN)
    busValid && busWrite && wordIdx == 1 && busWdata[15:0] == 16'h767B |=> lockState);

  a_r3_open_key: assert property (@(posedge clk) disable iff (!rstN)
    busValid && busWrite && wordIdx == 2 && busWdata[15:0] == 16'hDF0D |=> !lockState);

  a_r4_locked_write_flag: assert property (@(posedge clk) disable iff (!rstN)
    busValid && busWrite && lockState && wordIdx == 'h40 |=> accErr);

  a_r5_read_response: assert property (@(posedge clk) disable iff (!rstN)
    busValid && !busWrite |=> rspValid);

  a_r7_wo_read_flag: assert property (@(posedge clk) disable iff (!rstN)
    busValid && !busWrite && wordIdx == 1 |=> accErr);

  a_r9_soft_pulse: assert property (@(posedge clk) disable iff (!rstN)
    softRstReq |=> !softRstReq);

  a_r9_soft_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(softRstReq) |-> $past(busValid && busWrite && !lockState && wordIdx == 'h80 && busWdata[0]));
endmodule

bind keyRegFile keyRegFileChecker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) checker_i (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busWdata(busWdata), .lockState(lockState),
  .rspValid(rspValid), .accErr(accErr), .softRstReq(softRstReq)
);

// File: tb/keyRegFile_tb_top.sv
module keyRegFile_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ID = 32'h1C0D_E5A7;

  logic clk = 0, rstN = 0, busValid = 0, busWrite = 0;
  logic [3:0] bootStrap = 4'hA;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic rspValid, accErr, softRstReq;
  logic [31:0] rspData;

  int nChecks = 0, nFails = 0;
  logic [31:0] model [1024];
  bit modelLock;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyRegFile dut_i (.*);

  // 0 rw,1 ro,2 wo,3 none
  function automatic int cls(int w);
    int b = w * 4;
    if (b == 'h004 || b == 'h008 || b == 'h60C || b == 'h614) return 2;
    if (b == 'h00C || b == 'h10C || b == 'h25C || b == 'h530) return 1;
    if (b == 0 || (b >= 'h100 && b <= 'h108) || (b >= 'h120 && b <= 'h16C) ||
        (b >= 'h200 && b <= 'h244) || (b >= 'h700 && b <= 'h7D4)) return 0;
    return 3;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(bit wr, logic [11:0] a, logic [31:0] d, string tag);
    int w = a[11:2];
    int c = cls(w);
    bit expErr = 0, expSoft = 0, expV = 0;
    logic [31:0] expD = 'x;
    if (wr) begin
      if (w == 1) begin if (d[15:0] == 16'h767B) modelLock = 1; end
      else if (w == 2) begin if (d[15:0] == 16'hDF0D) modelLock = 0; end
      else if (c == 1 || c == 3 || modelLock) expErr = 1;
      else begin
        model[w] = (w == 0) ? {31'b0, d[0]} : d;
        expSoft = (w == 'h80) && d[0];
      end
    end else begin
      expV = 1;
      expErr = (c == 2 || c == 3);
      expD = (w == 3) ? {31'b0, modelLock} : model[w];
    end
    @(negedge clk);
    busValid = 1; busWrite = wr; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busValid = 0;
    check({tag, " rspValid"}, {31'b0, rspValid}, {31'b0, expV});
    check({tag, " accErr"}, {31'b0, accErr}, {31'b0, expErr});
    check({tag, " softRstReq"}, {31'b0, softRstReq}, {31'b0, expSoft});
    if (!wr) check({tag, " rspData"}, rspData, expD);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    automatic logic [11:0] pool [16] = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h100, 12'h10C,
      12'h124, 12'h200, 12'h204, 12'h25C, 12'h530, 12'h60C, 12'h700, 12'h7D4, 12'h7D8, 12'h900};
    void'($urandom(1234));
    for (int i = 0; i < 1024; i++) model[i] = 0;
    model['h10C >> 2] = 32'h3F; model['h25C >> 2] = 32'hA; model['h530 >> 2] = ID;
    modelLock = 1;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;
    check("R9 reset softRstReq", {31'b0, softRstReq}, 0);
    access(0, 12'h00C, 0, "R1 lockstatus");
    access(0, 12'h10C, 0, "R1 pllstatus");
    access(0, 12'h25C, 0, "R1 boot");
    access(0, 12'h530, 0, "R1 ident");
    access(0, 12'h124, 0, "R1 zero");
    access(1, 12'h124, 32'h5555_AAAA, "R4 locked write");
    access(0, 12'h124, 0, "R4 readback");
    access(1, 12'h008, 32'hFFFF_DF0C, "R3 wrong open key");
    access(0, 12'h00C, 0, "R3 still locked");
    access(1, 12'h008, 32'h1234_DF0D, "R3 open key");
    access(0, 12'h00C, 0, "R3 unlocked");
    access(1, 12'h124, 32'h5555_AAAA, "R5 write");
    access(0, 12'h124, 0, "R5 read");
    access(1, 12'h10C, 32'h1, "R6 ro write");
    access(0, 12'h10C, 0, "R6 ro unchanged");
    access(1, 12'h900, 32'h7, "R6 unmapped write");
    access(0, 12'h900, 0, "R7 unmapped read");
    access(1, 12'h60C, 32'hCAFE_0001, "R7 wo write");
    access(0, 12'h60C, 0, "R7 wo read");
    access(1, 12'h000, 32'hFFFF_FFFF, "R8 level write");
    access(0, 12'h000, 0, "R8 level read");
    access(1, 12'h200, 32'h0000_0002, "R9 bit0 clear");
    access(1, 12'h200, 32'h0000_0001, "R9 soft reset");
    for (int k = 0; k < 4; k++) begin
      access(1, 12'h700 | 12'(k), 32'h100 + k, "R10 alias write");
      access(0, 12'h700 | 12'(3 - k), 0, "R10 alias read");
    end
    access(1, 12'h004, 32'h0000_767A, "R2 wrong close key");
    access(0, 12'h00C, 0, "R2 still open");
    access(1, 12'h004, 32'hABCD_767B, "R2 close key");
    access(0, 12'h00C, 0, "R2 locked");
    access(1, 12'h200, 32'h1, "R9 locked no reset");
    for (int i = 0; i < 600; i++) begin
      automatic logic [11:0] a = pool[$urandom_range(15)] | 12'($urandom_range(3));
      automatic logic [31:0] d = $urandom;
      automatic bit wr = $urandom_range(1);
      if (a[11:2] == 1 && $urandom_range(1)) d[15:0] = 16'h767B;
      if (a[11:2] == 2 && $urandom_range(2) != 0) d[15:0] = 16'hDF0D;
      access(wr, a, d, "R5 R6 R7 random");
    end
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule